// File: doc/BRIEF.md
# Signed-Digit Radix-2 Fraction Divider

This block divides one sign-magnitude fraction by another, one quotient digit per clock. The partial remainder is held as a vector of signed digits in {-1, 0, +1}, each stored as a positive bit and a negative bit. Each iteration doubles the remainder and subtracts the divisor, adds it, or does neither. The result is formed digit by digit from a small per-digit rule plus a transfer bit from the neighbouring digit, so no carry runs across the word. The quotient digit comes from the top three remainder digits alone and does not look at the divisor. This works because the divisor is first normalised (prescaled) by a left shift, so that its leading magnitude bit is one.

After each update, the digits above the remainder's top position and the top digit itself are folded into a single digit. This keeps the remainder word the same width and means no overflow correction is ever needed. The quotient digits go through an on-the-fly converter. The converter keeps the running quotient and the running quotient minus one, so the result is available in binary the moment the last digit arrives. The redundant remainder goes through a single carry-propagate conversion at the end. If that remainder is negative, the quotient-minus-one register is taken as the result and the divisor is added back to the remainder.

A user pulses `start` with both operands present. `done` pulses when the results are ready. A zero divisor magnitude raises `div_zero` without iterating.

Top module: `sd_divider`

## Requirements
- R1: Each operand is W bits wide (M = W-1 magnitude bits): bit W-1 is the sign and bits M-1:0 hold the magnitude. For a nonzero divisor magnitude b and a dividend magnitude a with a < b, bits M-1:0 of `quotient` equal floor(a·2^M / b).
- R2: Under the same conditions, bits M-1:0 of `remainder` equal a·2^M − Q·b, where Q is the quotient magnitude. This value always lies in [0, b).
- R3: Bit W-1 of `quotient` is the XOR of the two operand signs. Bit W-1 of `remainder` is the dividend sign.
- R4: For a zero divisor magnitude, `done` and `div_zero` are high one cycle after the edge that accepts `start`, and `quotient` and `remainder` are all zero. A later division with a nonzero divisor returns `div_zero` low.
- R5: For a nonzero divisor, `done` is high M+k+2 cycles after the edge that accepts `start`, where k is the number of leading zero bits in the divisor magnitude.
- R6: `done` is a single-cycle pulse. `quotient`, `remainder` and `div_zero` change only in a cycle where `done` is high, and they are all zero out of reset.
- R7: A `start` pulse while a division is in progress is ignored. The running division completes with its original operands and no second `done` follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously by the caller |
| start | input | 1 | Begin a division with the current operands (taken when idle) |
| dividend | input | W | Sign-magnitude fraction dividend |
| divisor | input | W | Sign-magnitude fraction divisor |
| quotient | output | W | Sign-magnitude quotient, held until the next result |
| remainder | output | W | Sign-magnitude remainder, held until the next result |
| done | output | 1 | One-cycle result strobe |
| div_zero | output | 1 | Divisor magnitude was zero |

## Verification
The bench sweeps every dividend and divisor magnitude pair with a < b in a six-bit configuration, under all four sign combinations. Every prescale shift count, and hence every iteration count, occurs, so the latency checks separate a wrong normalisation or counter from a wrong digit rule. Dividends just below the divisor drive the remainder negative at the end, which exposes a missing quotient-minus-one selection or add-back, while small dividends over large divisors exercise long runs of zero and negative digits through the converter. Zero divisors, a start pulse in the middle of a run, and idle stretches after a result check the error path, the ignored start and the holding of results.

// File: rtl/sd_div_pkg.sv
`timescale 1ns/1ps
package sd_div_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SCALE = 2'd1,
    ST_ITER  = 2'd2,
    ST_FIN   = 2'd3
  } div_state_e;

  // quotient digit code: positive bit, negative bit
  typedef enum logic [1:0] {
    QD_ZERO = 2'b00,
    QD_NEG  = 2'b01,
    QD_POS  = 2'b10
  } qdig_e;

  function automatic logic signed [3:0] dval(input logic p, input logic n);
    if (p) return 4'sd1;
    if (n) return -4'sd1;
    return 4'sd0;
  endfunction

endpackage

// File: rtl/sd_prescale.sv
`timescale 1ns/1ps
module sd_prescale #(
  parameter int M  = 31,
  parameter int KW = $clog2(M + 1)
) (
  input  logic [M-1:0]  b_mag,
  output logic [M-1:0]  d_norm,
  output logic [KW-1:0] shift,
  output logic          is_zero
);

  logic hit;

  always_comb begin
    shift = '0;
    hit   = 1'b0;
    for (int i = M - 1; i >= 0; i--) begin
      if (!hit) begin
        if (b_mag[i]) hit = 1'b1;
        else          shift = shift + KW'(1);
      end
    end
  end

  assign d_norm  = b_mag << shift;
  assign is_zero = ~|b_mag;

endmodule

// File: rtl/sd_rem_step.sv
`timescale 1ns/1ps
module sd_rem_step
  import sd_div_pkg::*;
#(
  parameter int M = 31
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         active,
  input  logic [M:0]   rp,
  input  logic [M:0]   rn,
  input  logic [M-1:0] d,
  output qdig_e        qd,
  output logic [M:0]   np,
  output logic [M:0]   nn
);

  localparam int SW = M + 2;

  logic signed [3:0] est, top_t, fold;
  logic [SW-1:0] sp, sn, de, tn, tp, wodd, tn_in, tp_in, op, on;

  // digit estimate from the top three remainder digits only
  always_comb begin
    est = (dval(rp[M], rn[M]) <<< 2) + (dval(rp[M-1], rn[M-1]) <<< 1)
        + dval(rp[M-2], rn[M-2]);
    if (est > 0)      qd = QD_POS;
    else if (est < 0) qd = QD_NEG;
    else              qd = QD_ZERO;
  end

  assign sp = {rp, 1'b0};
  assign sn = {rn, 1'b0};
  assign de = {2'b00, d};

  // per-digit transfer and interim digit
  for (genvar i = 0; i < SW; i++) begin : g_cell
    assign tn[i]   = sn[i] | (de[i] & ~sp[i]);
    assign tp[i]   = sp[i] | (de[i] & ~sn[i]);
    assign wodd[i] = sp[i] ^ sn[i] ^ de[i];
  end

  assign tn_in = {tn[SW-2:0], 1'b0};
  assign tp_in = {tp[SW-2:0], 1'b0};

  always_comb begin
    unique case (qd)
      QD_POS: begin
        op    = wodd & ~tn_in;
        on    = tn_in & ~wodd;
        top_t = tn[SW-1] ? -4'sd1 : 4'sd0;
      end
      QD_NEG: begin
        op    = tp_in & ~wodd;
        on    = wodd & ~tp_in;
        top_t = tp[SW-1] ? 4'sd1 : 4'sd0;
      end
      default: begin
        op    = sp;
        on    = sn;
        top_t = 4'sd0;
      end
    endcase
    // fold transfer-out and the two top digits into one digit
    fold = (top_t <<< 2) + (dval(op[M+1], on[M+1]) <<< 1) + dval(op[M], on[M]);
  end

  assign np = {fold == 4'sd1,  op[M-1:0]};
  assign nn = {fold == -4'sd1, on[M-1:0]};

  // R1: the folded top digit always fits the digit set
  assert_fold_in_set_R1: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (fold >= -4'sd1 && fold <= 4'sd1));

endmodule

// File: rtl/sd_otf_conv.sv
`timescale 1ns/1ps
module sd_otf_conv
  import sd_div_pkg::*;
#(
  parameter int QW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          init,
  input  logic          en,
  input  qdig_e         qd,
  output logic [QW-1:0] q,
  output logic [QW-1:0] qm
);

  logic [QW-1:0] q_nx, qm_nx;
  logic          ld;

  assign ld = init | en;

  always_comb begin
    if (init) begin
      q_nx  = '0;
      qm_nx = '1;
    end else begin
      unique case (qd)
        QD_POS: begin
          q_nx  = {q[QW-2:0], 1'b1};
          qm_nx = {q[QW-2:0], 1'b0};
        end
        QD_NEG: begin
          q_nx  = {qm[QW-2:0], 1'b1};
          qm_nx = {qm[QW-2:0], 1'b0};
        end
        default: begin
          q_nx  = {q[QW-2:0], 1'b0};
          qm_nx = {qm[QW-2:0], 1'b1};
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q  <= '0;
      qm <= '1;
    end else if (ld) begin
      q  <= q_nx;
      qm <= qm_nx;
    end
  end

  // R1: the second register always trails the first by one
  assert_qm_trails_R1: assert property (@(posedge clk) disable iff (!rst_n)
    qm == q - QW'(1));

endmodule

// File: rtl/sd_divider.sv
`timescale 1ns/1ps
module sd_divider
  import sd_div_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         div_zero
);

  localparam int M  = W - 1;
  localparam int KW = $clog2(M + 1);
  localparam int CW = $clog2(2 * M);

  div_state_e st, st_nx;
  logic         sa, sb, cap_en;
  logic [M-1:0] a_mag, b_mag, d_reg, d_nx;
  logic [KW-1:0] k_reg, k_nx;
  logic [CW-1:0] cnt, cnt_nx;
  logic [M:0]   rp, rn, rp_nx, rn_nx;
  logic [W-1:0] quo_nx, rem_nx;
  logic         done_nx, dz_nx;

  logic [M-1:0] ps_d;
  logic [KW-1:0] ps_k;
  logic         ps_zero;
  qdig_e        qd;
  logic [M:0]   st_p, st_n, q_run, qm_run;
  logic         otf_init, otf_en, step_act;

  logic [M+1:0] rb, rc, rs;
  logic         r_neg;
  logic [M:0]   q_sel;

  sd_prescale #(.M(M), .KW(KW)) u_scale (
    .b_mag(b_mag), .d_norm(ps_d), .shift(ps_k), .is_zero(ps_zero));

  sd_rem_step #(.M(M)) u_step (
    .clk(clk), .rst_n(rst_n), .active(step_act), .rp(rp), .rn(rn),
    .d(d_reg), .qd(qd), .np(st_p), .nn(st_n));

  sd_otf_conv #(.QW(M + 1)) u_otf (
    .clk(clk), .rst_n(rst_n), .init(otf_init), .en(otf_en), .qd(qd),
    .q(q_run), .qm(qm_run));

  // single carry-propagate conversion of the final remainder
  always_comb begin
    rb    = {1'b0, rp} - {1'b0, rn};
    r_neg = rb[M+1];
    rc    = r_neg ? rb + {2'b00, d_reg} : rb;
    rs    = rc >> k_reg;
    q_sel = r_neg ? qm_run : q_run;
  end

  always_comb begin
    st_nx    = st;
    cap_en   = 1'b0;
    d_nx     = d_reg;
    k_nx     = k_reg;
    cnt_nx   = cnt;
    rp_nx    = rp;
    rn_nx    = rn;
    quo_nx   = quotient;
    rem_nx   = remainder;
    dz_nx    = div_zero;
    done_nx  = 1'b0;
    otf_init = 1'b0;
    otf_en   = 1'b0;
    step_act = 1'b0;
    unique case (st)
      ST_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          st_nx  = ST_SCALE;
        end
      end
      ST_SCALE: begin
        if (ps_zero) begin
          done_nx = 1'b1;
          dz_nx   = 1'b1;
          quo_nx  = '0;
          rem_nx  = '0;
          st_nx   = ST_IDLE;
        end else begin
          d_nx     = ps_d;
          k_nx     = ps_k;
          rp_nx    = {1'b0, a_mag};
          rn_nx    = '0;
          cnt_nx   = CW'(M - 1) + CW'(ps_k);
          otf_init = 1'b1;
          st_nx    = ST_ITER;
        end
      end
      ST_ITER: begin
        rp_nx    = st_p;
        rn_nx    = st_n;
        otf_en   = 1'b1;
        step_act = 1'b1;
        if (cnt == '0) st_nx = ST_FIN;
        else           cnt_nx = cnt - CW'(1);
      end
      default: begin
        quo_nx  = {sa ^ sb, q_sel[M-1:0]};
        rem_nx  = {sa, rs[M-1:0]};
        dz_nx   = 1'b0;
        done_nx = 1'b1;
        st_nx   = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      sa        <= 1'b0;
      sb        <= 1'b0;
      a_mag     <= '0;
      b_mag     <= '0;
      d_reg     <= '0;
      k_reg     <= '0;
      cnt       <= '0;
      rp        <= '0;
      rn        <= '0;
      quotient  <= '0;
      remainder <= '0;
      div_zero  <= 1'b0;
      done      <= 1'b0;
    end else begin
      st   <= st_nx;
      done <= done_nx;
      if (cap_en) begin
        sa    <= dividend[W-1];
        sb    <= divisor[W-1];
        a_mag <= dividend[M-1:0];
        b_mag <= divisor[M-1:0];
      end
      d_reg <= d_nx;
      k_reg <= k_nx;
      cnt   <= cnt_nx;
      rp    <= rp_nx;
      rn    <= rn_nx;
      if (done_nx) begin
        quotient  <= quo_nx;
        remainder <= rem_nx;
        div_zero  <= dz_nx;
      end
    end
  end

  // R1: no remainder digit ever holds the unused code
  assert_no_bad_digit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rp & rn) == '0);

  // R2: corrected remainder is in [0, divisor) and quotient fits
  assert_rem_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_FIN) |-> (!rc[M+1] && rc < {2'b00, d_reg} && !q_sel[M] && rs[M+1:M] == 2'b00));

  // R4: zero divisor ends the run on the next edge
  assert_zero_div_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SCALE && ps_zero) |=> (done && div_zero));

  // R6: strobe lasts one cycle, results hold otherwise
  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_zero)));

  // R7: operands are frozen while a run is in progress
  assert_ignore_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> ($stable(a_mag) && $stable(b_mag) && $stable(sa) && $stable(sb)));

endmodule

// File: tb/sd_divider_bench.sv
`timescale 1ns/1ps
module sd_divider_bench;

  localparam int BW = 6;
  localparam int BM = BW - 1;

  logic clk, rst_n, start, done, div_zero;
  logic [BW-1:0] dividend, divisor, quotient, remainder;
  int n_chk, n_fail;

  sd_divider #(.W(BW)) u_sd_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend),
    .divisor(divisor), .quotient(quotient), .remainder(remainder),
    .done(done), .div_zero(div_zero));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int lead_zeros(input int b);
    int z = 0;
    for (int i = BM - 1; i >= 0; i--) begin
      if (b[i]) break;
      z++;
    end
    return z;
  endfunction

  task automatic launch(input bit sa, input int am, input bit sb, input int bm);
    @(negedge clk);
    dividend = {sa, BM'(am)};
    divisor  = {sb, BM'(bm)};
    start    = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int lat);
    lat = 0;
    while (!done && lat < 80) begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end
  endtask

  task automatic check_result(input bit sa, input int am, input bit sb, input int bm, input int lat);
    if (bm == 0) begin
      chk(div_zero == 1'b1, "R4 div_zero", int'(div_zero), 1);
      chk(quotient == '0 && remainder == '0, "R4 zero results",
          int'({quotient, remainder}), 0);
      chk(lat == 1, "R4 latency", lat, 1);
    end else begin
      int eq = (am << BM) / bm;
      int er = (am << BM) % bm;
      chk(int'(quotient[BM-1:0]) == eq, "R1 quotient magnitude", int'(quotient[BM-1:0]), eq);
      chk(int'(remainder[BM-1:0]) == er, "R2 remainder magnitude", int'(remainder[BM-1:0]), er);
      chk(quotient[BM] == (sa ^ sb), "R3 quotient sign", int'(quotient[BM]), int'(sa ^ sb));
      chk(remainder[BM] == sa, "R3 remainder sign", int'(remainder[BM]), int'(sa));
      chk(lat == BM + lead_zeros(bm) + 2, "R5 latency", lat, BM + lead_zeros(bm) + 2);
      chk(div_zero == 1'b0, "R4 div_zero clear", int'(div_zero), 0);
    end
  endtask

  task automatic divide(input bit sa, input int am, input bit sb, input int bm);
    int lat;
    launch(sa, am, sb, bm);
    wait_done(lat);
    check_result(sa, am, sb, bm, lat);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int lat;
    logic [BW-1:0] hq, hr;
    n_chk = 0;
    n_fail = 0;
    rst_n = 1'b0;
    start = 1'b0;
    dividend = '0;
    divisor = '0;
    repeat (3) @(negedge clk);
    chk(done == 1'b0 && div_zero == 1'b0, "R6 reset strobes", int'({done, div_zero}), 0);
    chk(quotient == '0 && remainder == '0, "R6 reset results", int'({quotient, remainder}), 0);
    rst_n = 1'b1;

    // exhaustive sweep of a < b under all sign combinations
    for (int s = 0; s < 4; s++)
      for (int b = 1; b < (1 << BM); b++)
        for (int a = 0; a < b; a++)
          divide(s[0], a, s[1], b);

    // zero divisor, then recovery
    divide(1'b0, 7, 1'b0, 0);
    divide(1'b1, 0, 1'b1, 0);
    divide(1'b0, 3, 1'b1, 5);

    // results hold after the strobe
    hq = quotient;
    hr = remainder;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R6 single pulse", int'(done), 0);
      chk(quotient == hq && remainder == hr, "R6 hold", int'({quotient, remainder}), int'({hq, hr}));
    end

    // start during a run is ignored
    launch(1'b0, 3, 1'b1, 7);
    repeat (2) @(negedge clk);
    dividend = {1'b1, BM'(1)};
    divisor  = {1'b0, BM'(2)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    check_result(1'b0, 3, 1'b1, 7, lat + 3);
    chk(quotient[BM-1:0] == BM'((3 << BM) / 7), "R7 original operands used",
        int'(quotient[BM-1:0]), (3 << BM) / 7);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(done == 1'b0, "R7 no second result", int'(done), 0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule